// File: doc/BRIEF.md
# Phase-Frequency Detector with Windowed Lock Indicator

This block sits between the two programmable dividers of a frequency synthesizer and the tri-state charge pump. It watches the divided reference signal and the divided feedback signal, both synchronous to the reference-oscillator clock. For each pair of rising edges it raises either a pump-up or a pump-down enable. The enable lasts from the first edge until the second one arrives. When neither edge is pending, the pump is not driven, which corresponds to the high-impedance state.

The block also measures how far apart the two edges of each pair were, in oscillator clocks. A pair closer than two clocks counts as in-window. Lock is declared on the fourth in-window pair in a row and is withdrawn by the first pair outside the window. An indicator pin shows the lock flag, or a half-rate copy of either divided signal. In standby the pin is held high, the pump is idle, and all edge flags, counters and half-rate toggles are cleared.

Top module: `pfd_lock_core`

## Requirements
- R1: The pump drive output is high exactly while one edge of a pair is pending. For a pair whose second rising edge is sampled k clocks after the first, drive is high for k clocks. When both edges are sampled on the same clock, drive stays low.
- R2: When the reference edge leads, only pump-up pulses. When the feedback edge leads, only pump-down pulses. Pump-up and pump-down are never high together.
- R3: A pair with a separation below 2 clocks is in-window. The lock flag rises on the fourth consecutive in-window pair, in the clock after that pair's second edge, and not earlier.
- R4: Once locked, further in-window pairs keep the lock flag high, because the run counter saturates.
- R5: A single pair with a separation of 2 or more clocks clears the lock flag and the run count. Four new in-window pairs are then needed to lock again.
- R6: While standby is high, both pump enables and drive are low, the indicator pin is high, and edges are ignored. Leaving standby finds lock cleared and both half-rate toggles at 0.
- R7: With indicator select 00 or 11, the pin shows the lock flag when the enable input is 1. It is forced low when the enable is 0 and standby is low.
- R8: Indicator select 01 shows the reference divided by 2, and select 10 shows the feedback divided by 2. Each toggle starts at 0 after reset and changes on every sampled rising edge of its own signal.
- R9: After reset, both pump enables and drive are low, and with select 00 and the enable set, the pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_div_i | input | 1 | Divided reference signal, synchronous to clk |
| fb_div_i | input | 1 | Divided feedback signal, synchronous to clk |
| standby_i | input | 1 | Standby request |
| ind_en_i | input | 1 | Lock indicator enable |
| ind_sel_i | input | 2 | Indicator source: 00/11 lock, 01 reference/2, 10 feedback/2 |
| pump_up_o | output | 1 | Charge pump source enable |
| pump_dn_o | output | 1 | Charge pump sink enable |
| pump_drive_o | output | 1 | Pump driven; low means high-impedance |
| lock_pin_o | output | 1 | Indicator pin |

## Verification
A rising input level is sampled on the first clock edge after it changes. A pump pulse therefore opens on that edge and closes on the edge that samples the lagging signal, so the bench counts pump-high clocks at falling edges to get the pulse width k directly. The lock flag is registered on the edge that completes a pair. The half-rate toggles are registered on the edge that samples their rising input. The bench therefore compares the pin only once each pair has ended and the inputs have rested a few clocks, when every registered result has settled. Standby gating and the enable gating are combinational, so those checks sample the pin in the same low phase in which the control input changed.

// File: rtl/pfd_lock_pkg.sv
package pfd_lock_pkg;

    typedef enum logic [1:0] {
        IND_LOCK      = 2'b00,
        IND_REF_HALF  = 2'b01,
        IND_FB_HALF   = 2'b10,
        IND_LOCK_ALT  = 2'b11
    } ind_sel_e;

    localparam int unsigned DEF_WIN_CLKS = 2;
    localparam int unsigned DEF_LOCK_RUN = 4;

endpackage

// File: rtl/pfd_edge_flags.sv
module pfd_edge_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic standby_i,
    input  logic ref_i,
    input  logic fb_i,
    output logic up_o,
    output logic dn_o,
    output logic ref_rise_o,
    output logic fb_rise_o,
    output logic done_o
);

    typedef struct packed {
        logic ref_prev;
        logic fb_prev;
        logic up;
        logic dn;
    } flag_st_t;

    flag_st_t st_d, st_q;
    logic ref_rise, fb_rise, both_seen;

    always_comb begin
        ref_rise  = ref_i & ~st_q.ref_prev;
        fb_rise   = fb_i & ~st_q.fb_prev;
        both_seen = (st_q.up | ref_rise) & (st_q.dn | fb_rise);

        st_d          = st_q;
        st_d.ref_prev = ref_i;
        st_d.fb_prev  = fb_i;
        if (standby_i || both_seen) begin
            st_d.up = 1'b0;
            st_d.dn = 1'b0;
        end else begin
            st_d.up = st_q.up | ref_rise;
            st_d.dn = st_q.dn | fb_rise;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign up_o       = st_q.up;
    assign dn_o       = st_q.dn;
    assign ref_rise_o = ref_rise & ~standby_i;
    assign fb_rise_o  = fb_rise & ~standby_i;
    assign done_o     = both_seen & ~standby_i;

    // R1: a completed pair leaves no pending flag behind
    assert_clear_after_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!up_o && !dn_o));

    // R6: standby empties both flags on the next clock
    assert_standby_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        standby_i |=> (!up_o && !dn_o));

endmodule

// File: rtl/pfd_lock_window.sv
module pfd_lock_window #(
    parameter int unsigned WIN_CLKS = 2,
    parameter int unsigned LOCK_RUN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic standby_i,
    input  logic up_i,
    input  logic dn_i,
    input  logic done_i,
    output logic locked_o
);

    localparam int unsigned EW   = $clog2(WIN_CLKS + 1);
    localparam int unsigned SEPW = EW + 1;
    localparam int unsigned CW   = $clog2(LOCK_RUN + 1);

    typedef struct packed {
        logic [EW-1:0] err;
        logic [CW-1:0] run;
        logic          locked;
    } win_st_t;

    win_st_t st_d, st_q;
    logic            one_pend;
    logic [SEPW-1:0] sep;
    logic            in_win;

    always_comb begin
        one_pend = up_i ^ dn_i;
        sep      = {1'b0, st_q.err} + {{EW{1'b0}}, one_pend};
        in_win   = sep < SEPW'(WIN_CLKS);

        st_d = st_q;
        if (standby_i) begin
            st_d = '0;
        end else if (done_i) begin
            st_d.err = '0;
            if (in_win) begin
                if (st_q.run != CW'(LOCK_RUN)) st_d.run = st_q.run + 1'b1;
                st_d.locked = (st_q.run >= CW'(LOCK_RUN - 1));
            end else begin
                st_d.run    = '0;
                st_d.locked = 1'b0;
            end
        end else if (one_pend && st_q.err != EW'(WIN_CLKS)) begin
            st_d.err = st_q.err + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign locked_o = st_q.locked;

    // R3: lock only rises after enough in-window pairs were already counted
    assert_lock_needs_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> ($past(st_q.run) >= CW'(LOCK_RUN - 1)));

    // R4: a locked loop stays locked through an in-window pair
    assert_stays_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && done_i && in_win && !standby_i) |=> locked_o);

    // R5: one out-of-window pair drops lock and the run count
    assert_drop_on_wide_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !in_win && !standby_i) |=> (!locked_o && st_q.run == '0));

endmodule

// File: rtl/pfd_ind_mux.sv
module pfd_ind_mux
    import pfd_lock_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       standby_i,
    input  logic       ref_rise_i,
    input  logic       fb_rise_i,
    input  logic       locked_i,
    input  logic       ind_en_i,
    input  logic [1:0] ind_sel_i,
    output logic       pin_o
);

    typedef struct packed {
        logic ref_half;
        logic fb_half;
    } half_st_t;

    half_st_t st_d, st_q;
    ind_sel_e sel;

    always_comb begin
        st_d = st_q;
        if (standby_i) begin
            st_d = '0;
        end else begin
            if (ref_rise_i) st_d.ref_half = ~st_q.ref_half;
            if (fb_rise_i)  st_d.fb_half  = ~st_q.fb_half;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        sel = ind_sel_e'(ind_sel_i);
        if (standby_i) begin
            pin_o = 1'b1;
        end else begin
            case (sel)
                IND_REF_HALF: pin_o = st_q.ref_half;
                IND_FB_HALF:  pin_o = st_q.fb_half;
                default:      pin_o = locked_i & ind_en_i;
            endcase
        end
    end

    // R6: standby holds the pin high
    assert_standby_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
        standby_i |-> pin_o);

    // R8: the half-rate reference copy changes only after a sampled reference edge
    assert_ref_half_moves_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ref_rise_i) && !$past(standby_i)) |-> $stable(st_q.ref_half));

endmodule

// File: rtl/pfd_lock_core.sv
module pfd_lock_core
    import pfd_lock_pkg::*;
#(
    parameter int unsigned WIN_CLKS = DEF_WIN_CLKS,
    parameter int unsigned LOCK_RUN = DEF_LOCK_RUN
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_div_i,
    input  logic       fb_div_i,
    input  logic       standby_i,
    input  logic       ind_en_i,
    input  logic [1:0] ind_sel_i,
    output logic       pump_up_o,
    output logic       pump_dn_o,
    output logic       pump_drive_o,
    output logic       lock_pin_o
);

    logic up_flag, dn_flag, ref_rise, fb_rise, pair_done, locked;

    pfd_edge_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .standby_i  (standby_i),
        .ref_i      (ref_div_i),
        .fb_i       (fb_div_i),
        .up_o       (up_flag),
        .dn_o       (dn_flag),
        .ref_rise_o (ref_rise),
        .fb_rise_o  (fb_rise),
        .done_o     (pair_done)
    );

    pfd_lock_window #(
        .WIN_CLKS (WIN_CLKS),
        .LOCK_RUN (LOCK_RUN)
    ) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .standby_i (standby_i),
        .up_i      (up_flag),
        .dn_i      (dn_flag),
        .done_i    (pair_done),
        .locked_o  (locked)
    );

    pfd_ind_mux u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .standby_i  (standby_i),
        .ref_rise_i (ref_rise),
        .fb_rise_i  (fb_rise),
        .locked_i   (locked),
        .ind_en_i   (ind_en_i),
        .ind_sel_i  (ind_sel_i),
        .pin_o      (lock_pin_o)
    );

    assign pump_up_o    = up_flag & ~standby_i;
    assign pump_dn_o    = dn_flag & ~standby_i;
    assign pump_drive_o = pump_up_o ^ pump_dn_o;

    // R2: the pump never sources and sinks at once
    assert_one_direction_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(pump_up_o && pump_dn_o));

    // R6: the pump is idle during standby
    assert_standby_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        standby_i |-> (!pump_up_o && !pump_dn_o && !pump_drive_o));

    // R1: a pulse can only open on a sampled edge of either divided signal
    assert_pulse_needs_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pump_drive_o) |-> ($past(ref_rise) || $past(fb_rise)));

endmodule

// File: tb/pfd_lock_core_bench.sv
module pfd_lock_core_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_div = 1'b0;
    logic       fb_div = 1'b0;
    logic       standby = 1'b0;
    logic       ind_en = 1'b1;
    logic [1:0] ind_sel = 2'b00;
    logic       pump_up, pump_dn, pump_drive, lock_pin;

    pfd_lock_core u_pfd_lock_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .ref_div_i    (ref_div),
        .fb_div_i     (fb_div),
        .standby_i    (standby),
        .ind_en_i     (ind_en),
        .ind_sel_i    (ind_sel),
        .pump_up_o    (pump_up),
        .pump_dn_o    (pump_dn),
        .pump_drive_o (pump_drive),
        .lock_pin_o   (lock_pin)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        int    up_w;
        int    dn_w;
        int    drv_w;
        bit    chk_pin;
        bit    pin;
        string tag;
    } item_t;

    item_t exp_q[$];
    int    checks = 0;
    int    errors = 0;
    int    model_run = 0;
    int    ref_rises = 0;
    int    fb_rises = 0;
    int    up_acc = 0, dn_acc = 0, drv_acc = 0;
    bit    done_flag = 1'b0;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // low phase of the current cycle, for combinational results
    task automatic settle();
        @(negedge clk);
    endtask

    // monitor: counts pump clocks, pops one expected item per finished pair
    always @(negedge clk) begin
        if (rst_n) begin
            if (pump_up)    up_acc++;
            if (pump_dn)    dn_acc++;
            if (pump_drive) drv_acc++;
            if (done_flag && exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                chk({"R2 up width ", it.tag}, up_acc, it.up_w);
                chk({"R2 dn width ", it.tag}, dn_acc, it.dn_w);
                chk({"R1 drive width ", it.tag}, drv_acc, it.drv_w);
                if (it.chk_pin) chk({"pin ", it.tag}, int'(lock_pin), int'(it.pin));
                up_acc = 0;
                dn_acc = 0;
                drv_acc = 0;
            end
        end
    end

    // driver: one edge pair with separation k, pushes the expected result
    task automatic pair(int k, bit ref_first, bit chk_pin, string tag);
        item_t it;
        it.up_w    = (k > 0 && ref_first)  ? k : 0;
        it.dn_w    = (k > 0 && !ref_first) ? k : 0;
        it.drv_w   = k;
        if (k < 2) model_run = (model_run < 4) ? model_run + 1 : 4;
        else       model_run = 0;
        it.chk_pin = chk_pin;
        it.pin     = (model_run >= 4);
        it.tag     = tag;
        exp_q.push_back(it);
        ref_rises++;
        fb_rises++;
        tick();
        if (k == 0) begin
            ref_div = 1'b1;
            fb_div  = 1'b1;
        end else begin
            if (ref_first) ref_div = 1'b1;
            else           fb_div  = 1'b1;
            repeat (k) tick();
            ref_div = 1'b1;
            fb_div  = 1'b1;
        end
        repeat (2) tick();
        ref_div = 1'b0;
        fb_div  = 1'b0;
        repeat (3) tick();
        done_flag = 1'b1;
        tick();
        done_flag = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        settle();
        chk("R9 reset pump_up", int'(pump_up), 0);
        chk("R9 reset pump_dn", int'(pump_dn), 0);
        chk("R9 reset drive", int'(pump_drive), 0);
        chk("R9 reset pin", int'(lock_pin), 0);

        // R3: three in-window pairs do not lock, the fourth does
        pair(0, 1'b1, 1'b1, "R3 pair1 simultaneous");
        pair(1, 1'b1, 1'b1, "R3 pair2 ref leads 1");
        pair(1, 1'b0, 1'b1, "R3 pair3 fb leads 1");
        pair(0, 1'b0, 1'b1, "R3 pair4 lock");
        // R4: saturated, stays locked
        pair(1, 1'b1, 1'b1, "R4 pair5 keep lock");
        pair(0, 1'b1, 1'b1, "R4 pair6 keep lock");
        // R5: a wide pair drops lock; separation of exactly 2 is out of window
        pair(3, 1'b1, 1'b1, "R5 wide ref leads 3");
        pair(2, 1'b0, 1'b1, "R5 boundary fb leads 2");
        pair(1, 1'b1, 1'b1, "R5 relock 1");
        pair(0, 1'b1, 1'b1, "R5 relock 2");
        pair(1, 1'b0, 1'b1, "R5 relock 3");
        pair(1, 1'b1, 1'b1, "R5 relock 4");

        // R7: enable low forces pin low while locked
        ind_en = 1'b0;
        settle();
        chk("R7 enable low pin", int'(lock_pin), 0);
        tick();
        ind_sel = 2'b11;
        settle();
        chk("R7 enable low alt select pin", int'(lock_pin), 0);
        tick();
        ind_en = 1'b1;
        settle();
        chk("R7 enable high alt select pin", int'(lock_pin), 1);
        tick();
        ind_sel = 2'b00;

        // R6: standby
        standby = 1'b1;
        settle();
        chk("R6 standby pin high", int'(lock_pin), 1);
        tick();
        ref_div = 1'b1;
        tick();
        settle();
        chk("R6 standby edge pump_up", int'(pump_up), 0);
        chk("R6 standby edge drive", int'(pump_drive), 0);
        tick();
        ref_div = 1'b0;
        tick();
        standby = 1'b0;
        model_run = 0;
        ref_rises = 0;
        fb_rises = 0;
        settle();
        chk("R6 lock cleared after standby", int'(lock_pin), 0);
        chk("R6 no pending pulse after standby", int'(pump_drive), 0);
        tick();

        // R8: half-rate outputs
        ind_sel = 2'b01;
        settle();
        chk("R8 ref half start", int'(lock_pin), 0);
        tick();
        pair(0, 1'b1, 1'b0, "R8 pair a");
        ind_sel = 2'b01;
        settle();
        chk("R8 ref half after 1 edge", int'(lock_pin), ref_rises % 2);
        tick();
        ind_sel = 2'b10;
        settle();
        chk("R8 fb half after 1 edge", int'(lock_pin), fb_rises % 2);
        tick();
        pair(1, 1'b0, 1'b0, "R8 pair b");
        settle();
        chk("R8 fb half after 2 edges", int'(lock_pin), fb_rises % 2);
        tick();
        ind_sel = 2'b01;
        settle();
        chk("R8 ref half after 2 edges", int'(lock_pin), ref_rises % 2);
        tick();
        ind_sel = 2'b00;
        settle();
        chk("R7 lock select after 2 pairs", int'(lock_pin), 0);
        tick();

        repeat (4) tick();
        chk("R1 scoreboard drained", exp_q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule